// File: doc/BRIEF.md
# Two-Level Virtual Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level table in memory. The ten top address bits select a word in a segment table. That word gives the frame of a page table. The next ten bits select a word in that page table, and the page word gives the physical frame. The low twelve bits are the byte offset inside a 4 KB page and pass through unchanged. Supervisor and user accesses start from separate root frames. Translation can be switched off for each mode on its own, and then the address passes straight through.

While it walks, the block checks the valid and write-protect bits of both table words. A successful access writes the page word back with its reference bit set, and with its modify bit set as well for a write. The write-back happens only when one of those bits actually changes. Faults are recorded in a status word whose fault bits stay set until software overwrites them. A request either returns a physical address and a cache-inhibit flag, or returns a fault. The walker serves one request at a time.

Top module: `xlate_walker`

## Requirements
- R1: Addresses are formed as follows. The segment word is read at (root frame × 4096) + VA[31:22] × 4. The page word is read at (segment word & 0xFFFFF000) + VA[21:12] × 4. The physical address is (page word & 0xFFFFF000) | VA[11:0].
- R2: A request with `req_super`=1 walks from the supervisor root frame. A request with `req_super`=0 walks from the user root frame.
- R3: A segment word is valid only when its bit 1 is set; its bit 0 is ignored. An invalid segment word ends the walk without a page read and sets status bits 15 and 3.
- R4: A page word is valid only when its bit 0 is set; its bit 1 is ignored. An invalid page word sets status bits 14 and 3.
- R5: Bit 2 of a segment or page word marks it read-only. A write through either one faults and sets status bits 13 and 3, and a write to a read-only segment does not read the page word. Reads of read-only entries succeed. The checks run in this order: segment valid, segment protect, page valid, page protect.
- R6: After a successful walk the page word is written back with bit 3 (reference) set, and also bit 4 (modify) for a write. The write happens only when the word changes. A faulting walk writes nothing.
- R7: On success `rsp_cinh` equals bit 6 of the page word.
- R8: Status bits 15, 14, 13 and 3 stay set until a register write to the status word (select 2) changes them. A later successful walk does not clear them.
- R9: Status bit 1 enables supervisor translation and bit 0 enables user translation. With the mode's bit clear, the response has `rsp_paddr` = VA and `rsp_cinh`=0, and no memory access takes place.
- R10: A faulting response has `rsp_fault`=1, `rsp_paddr`=0 and `rsp_cinh`=0.
- R11: `req_ready` is low from acceptance until the response. `rsp_valid` lasts one cycle.
- R12: The register port selects 0 = supervisor root frame (20 bits), 1 = user root frame (20 bits) and 2 = status. A write takes effect at the clock edge. `reg_rdata` follows `reg_sel` combinationally. Status bits other than 15, 14, 13, 3, 1 and 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is in supervisor mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_cinh | output | 1 | Cache inhibit of the page |
| rsp_fault | output | 1 | Walk faulted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of table word |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The response is due a fixed number of cycles after the accepting edge:
- 1 cycle for a pass-through.
- 3 cycles for a segment-level fault.
- 5 cycles for a page-level fault or a walk that needs no write-back.
- 6 cycles for a walk with a write-back.

The bench works out that latency from its own copy of the tables before it issues each request. At every falling edge inside the window it compares `rsp_valid` and `req_ready` with the expected values, so an early, late or repeated response is caught in the exact cycle. At the response cycle it also checks the status word, the number of memory accesses and the page word left in memory.

// File: rtl/xw_pkg.sv
package xw_pkg;
  parameter int unsigned AW    = 32;
  parameter int unsigned OFF_W = 12;
  parameter int unsigned IDX_W = 10;
  localparam int unsigned FRAME_W = AW - OFF_W;
  localparam int unsigned SEL_W   = 2;

  // entry bit positions (behavioural: decoded by software and walker)
  localparam int unsigned SEG_V  = 1;
  localparam int unsigned SEG_RO = 2;
  localparam int unsigned PG_V   = 0;
  localparam int unsigned PG_RO  = 2;
  localparam int unsigned PG_REF = 3;
  localparam int unsigned PG_MOD = 4;
  localparam int unsigned PG_CI  = 6;

  // status word bit positions
  localparam int unsigned ST_PTF  = 15;
  localparam int unsigned ST_PF   = 14;
  localparam int unsigned ST_PROT = 13;
  localparam int unsigned ST_BERR = 3;
  localparam int unsigned ST_SEN  = 1;
  localparam int unsigned ST_UEN  = 0;

  localparam logic [SEL_W-1:0] SEL_SROOT = 2'd0;
  localparam logic [SEL_W-1:0] SEL_UROOT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT  = 2'd2;

  typedef enum logic [2:0] {
    W_IDLE, W_SEG, W_SEGCHK, W_PG, W_PGCHK, W_WB, W_RESP
  } wstate_e;

  typedef enum logic [1:0] {F_NONE, F_PTF, F_PF, F_PROT} fault_e;

  function automatic logic [AW-1:0] seg_word_addr(
      input logic [FRAME_W-1:0] root, input logic [AW-1:0] va);
    logic [AW-1:0] a;
    a = {root, {OFF_W{1'b0}}};
    a[IDX_W+1:2] = va[AW-1 -: IDX_W];
    return a;
  endfunction

  function automatic logic [AW-1:0] pg_word_addr(
      input logic [AW-1:0] ste, input logic [AW-1:0] va);
    logic [AW-1:0] a;
    a = {ste[AW-1:OFF_W], {OFF_W{1'b0}}};
    a[IDX_W+1:2] = va[OFF_W+IDX_W-1 -: IDX_W];
    return a;
  endfunction

  function automatic logic [AW-1:0] phys_addr(
      input logic [AW-1:0] pte, input logic [AW-1:0] va);
    return {pte[AW-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [AW-1:0] pte_touched(
      input logic [AW-1:0] pte, input logic wr);
    logic [AW-1:0] p;
    p = pte;
    p[PG_REF] = 1'b1;
    if (wr) p[PG_MOD] = 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/xw_regs.sv
module xw_regs
  import xw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [AW-1:0]       reg_wdata,
  input  logic                fault_evt,
  input  fault_e              fault_kind,
  output logic [FRAME_W-1:0]  sroot,
  output logic [FRAME_W-1:0]  uroot,
  output logic                sen,
  output logic                uen,
  output logic [AW-1:0]       reg_rdata
);
  logic [FRAME_W-1:0] sroot_q, uroot_q;
  logic ptf_q, pf_q, prot_q, berr_q, sen_q, uen_q;

  wire wr_sroot = reg_wen && (reg_sel == SEL_SROOT);
  wire wr_uroot = reg_wen && (reg_sel == SEL_UROOT);
  wire wr_stat  = reg_wen && (reg_sel == SEL_STAT);
  wire set_ptf  = fault_evt && (fault_kind == F_PTF);
  wire set_pf   = fault_evt && (fault_kind == F_PF);
  wire set_prot = fault_evt && (fault_kind == F_PROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sroot_q <= '0; uroot_q <= '0;
      ptf_q <= 1'b0; pf_q <= 1'b0; prot_q <= 1'b0; berr_q <= 1'b0;
      sen_q <= 1'b0; uen_q <= 1'b0;
    end else begin
      if (wr_sroot) sroot_q <= reg_wdata[FRAME_W-1:0];
      if (wr_uroot) uroot_q <= reg_wdata[FRAME_W-1:0];
      if (wr_stat) begin
        sen_q <= reg_wdata[ST_SEN];
        uen_q <= reg_wdata[ST_UEN];
      end
      // hardware set wins over a simultaneous software write
      ptf_q  <= (wr_stat ? reg_wdata[ST_PTF]  : ptf_q)  | set_ptf;
      pf_q   <= (wr_stat ? reg_wdata[ST_PF]   : pf_q)   | set_pf;
      prot_q <= (wr_stat ? reg_wdata[ST_PROT] : prot_q) | set_prot;
      berr_q <= (wr_stat ? reg_wdata[ST_BERR] : berr_q) | fault_evt;
    end
  end

  logic [AW-1:0] stat_w;
  always_comb begin
    stat_w = '0;
    stat_w[ST_PTF]  = ptf_q;
    stat_w[ST_PF]   = pf_q;
    stat_w[ST_PROT] = prot_q;
    stat_w[ST_BERR] = berr_q;
    stat_w[ST_SEN]  = sen_q;
    stat_w[ST_UEN]  = uen_q;
    unique case (reg_sel)
      SEL_SROOT: reg_rdata = AW'(sroot_q);
      SEL_UROOT: reg_rdata = AW'(uroot_q);
      SEL_STAT:  reg_rdata = stat_w;
      default:   reg_rdata = '0;
    endcase
  end

  assign sroot = sroot_q;
  assign uroot = uroot_q;
  assign sen   = sen_q;
  assign uen   = uen_q;

  a_r8_ptf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ptf_q && !wr_stat) |=> ptf_q);
  a_r8_pf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_q && !wr_stat) |=> pf_q);
  a_r8_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && !wr_stat) |=> prot_q);
  a_r3_berr_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (berr_q && $countones({ptf_q, pf_q, prot_q}) >= 1));
endmodule

// File: rtl/xw_walk.sv
module xw_walk
  import xw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_vaddr,
  input  logic                req_write,
  input  logic                req_super,
  output logic                rsp_valid,
  output logic [AW-1:0]       rsp_paddr,
  output logic                rsp_cinh,
  output logic                rsp_fault,
  output logic                mem_en,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [AW-1:0]       mem_wdata,
  input  logic [AW-1:0]       mem_rdata,
  input  logic [FRAME_W-1:0]  sroot,
  input  logic [FRAME_W-1:0]  uroot,
  input  logic                sen,
  input  logic                uen,
  output logic                fault_evt,
  output fault_e              fault_kind
);
  wstate_e            st_q;
  logic [AW-1:0]      va_q, ste_q, pte_new_q, paddr_q;
  logic [FRAME_W-1:0] root_q;
  logic               wr_q, cinh_q;
  fault_e             fault_q;

  // named internal events
  wire accept_w   = (st_q == W_IDLE) && req_valid;
  wire xl_en_w    = req_super ? sen : uen;
  wire seg_inv_w  = (st_q == W_SEGCHK) && !mem_rdata[SEG_V];
  wire seg_prot_w = (st_q == W_SEGCHK) && mem_rdata[SEG_V] && wr_q && mem_rdata[SEG_RO];
  wire pg_inv_w   = (st_q == W_PGCHK) && !mem_rdata[PG_V];
  wire pg_prot_w  = (st_q == W_PGCHK) && mem_rdata[PG_V] && wr_q && mem_rdata[PG_RO];
  wire pg_ok_w    = (st_q == W_PGCHK) && mem_rdata[PG_V] && !(wr_q && mem_rdata[PG_RO]);
  wire [AW-1:0] pte_upd_w = pte_touched(mem_rdata, wr_q);
  wire wb_need_w  = pte_upd_w != mem_rdata;

  always_comb begin
    fault_evt  = seg_inv_w || seg_prot_w || pg_inv_w || pg_prot_w;
    fault_kind = F_NONE;
    if (seg_inv_w)                    fault_kind = F_PTF;
    else if (pg_inv_w)                fault_kind = F_PF;
    else if (seg_prot_w || pg_prot_w) fault_kind = F_PROT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; va_q <= '0; ste_q <= '0; pte_new_q <= '0;
      paddr_q <= '0; root_q <= '0; wr_q <= 1'b0; cinh_q <= 1'b0;
      fault_q <= F_NONE;
    end else begin
      unique case (st_q)
        W_IDLE: if (accept_w) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          root_q  <= req_super ? sroot : uroot;
          fault_q <= F_NONE;
          cinh_q  <= 1'b0;
          paddr_q <= req_vaddr;
          st_q    <= xl_en_w ? W_SEG : W_RESP;
        end
        W_SEG: st_q <= W_SEGCHK;
        W_SEGCHK: begin
          if (fault_evt) begin
            fault_q <= fault_kind;
            paddr_q <= '0;
            st_q    <= W_RESP;
          end else begin
            ste_q <= mem_rdata;
            st_q  <= W_PG;
          end
        end
        W_PG: st_q <= W_PGCHK;
        W_PGCHK: begin
          if (fault_evt) begin
            fault_q <= fault_kind;
            paddr_q <= '0;
            st_q    <= W_RESP;
          end else begin
            paddr_q   <= phys_addr(mem_rdata, va_q);
            cinh_q    <= mem_rdata[PG_CI];
            pte_new_q <= pte_upd_w;
            st_q      <= wb_need_w ? W_WB : W_RESP;
          end
        end
        W_WB:   st_q <= W_RESP;
        W_RESP: st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (st_q == W_IDLE);
    rsp_valid = (st_q == W_RESP);
    rsp_fault = rsp_valid && (fault_q != F_NONE);
    rsp_paddr = rsp_valid ? paddr_q : '0;
    rsp_cinh  = rsp_valid && cinh_q;
    mem_en    = (st_q == W_SEG) || (st_q == W_PG) || (st_q == W_WB);
    mem_we    = (st_q == W_WB);
    mem_wdata = (st_q == W_WB) ? pte_new_q : '0;
    unique case (st_q)
      W_SEG:       mem_addr = seg_word_addr(root_q, va_q);
      W_PG, W_WB:  mem_addr = pg_word_addr(ste_q, va_q);
      default:     mem_addr = '0;
    endcase
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r11_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  a_r10_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_cinh));
  a_r6_wb_marks_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_wdata[PG_REF] && mem_wdata[PG_V]));
  a_r3_ptf_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && fault_kind == F_PTF) |=> (rsp_valid && !mem_en));
  a_r5_fault_then_respond: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (rsp_valid && rsp_fault));
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_vaddr,
  input  logic             req_write,
  input  logic             req_super,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_paddr,
  output logic             rsp_cinh,
  output logic             rsp_fault,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic [AW-1:0]    mem_rdata,
  input  logic             reg_wen,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata
);
  logic [FRAME_W-1:0] sroot, uroot;
  logic               sen, uen, fault_evt;
  fault_e             fault_kind;

  xw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .fault_evt(fault_evt), .fault_kind(fault_kind),
    .sroot(sroot), .uroot(uroot), .sen(sen), .uen(uen), .reg_rdata(reg_rdata)
  );

  xw_walk u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cinh(rsp_cinh),
    .rsp_fault(rsp_fault), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sroot(sroot), .uroot(uroot), .sen(sen), .uen(uen),
    .fault_evt(fault_evt), .fault_kind(fault_kind)
  );
endmodule

// File: tb/xlate_walker_tb_top.sv
`timescale 1ns/100ps
module xlate_walker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_super = 0;
  logic [31:0] req_vaddr = 0;
  logic req_ready, rsp_valid, rsp_cinh, rsp_fault, mem_en, mem_we;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata, reg_rdata;
  logic [31:0] mem_rdata = 0;
  logic reg_wen = 0;
  logic [1:0] reg_sel = 2'd2;
  logic [31:0] reg_wdata = 0;

  int checks = 0, fails = 0, mem_cnt = 0;
  bit done = 0;
  logic [31:0] bmem [int unsigned];
  logic [31:0] m_sroot = 0, m_uroot = 0, m_stat = 0;

  always #2.5 clk = ~clk;

  xlate_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cinh(rsp_cinh),
    .rsp_fault(rsp_fault), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_wen(reg_wen), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (bmem.exists(a >> 2)) return bmem[a >> 2];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      mem_cnt = mem_cnt + 1;
      if (mem_we) bmem[mem_addr >> 2] = mem_wdata;
      else mem_rdata <= rd(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0; reg_sel = 2'd2;
    case (sel)
      2'd0: m_sroot = d & 32'h000F_FFFF;
      2'd1: m_uroot = d & 32'h000F_FFFF;
      2'd2: m_stat  = d & 32'h0000_E00B;
      default: ;
    endcase
  endtask

  task automatic rreg(input logic [1:0] sel, input logic [31:0] exp, input string req);
    reg_sel = sel; #0.5;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    reg_sel = 2'd2;
  endtask

  // behavioural model of one translation, then a per-cycle comparison
  task automatic xlate(input logic [31:0] va, input bit wr, input bit sup,
                       input string req);
    logic [31:0] ste, pte, pa, pga, newpte;
    bit en, f, ci, wb;
    int lat, acc;
    pa = 0; ci = 0; f = 0; wb = 0; pga = 0; newpte = 0;
    en = sup ? m_stat[1] : m_stat[0];
    if (!en) begin
      lat = 1; acc = 0; pa = va;
    end else begin
      ste = rd(((sup ? m_sroot : m_uroot) << 12) + ((va >> 22) * 4));
      if (!ste[1]) begin
        f = 1; lat = 3; acc = 1; m_stat = m_stat | 32'h8008;
      end else if (wr && ste[2]) begin
        f = 1; lat = 3; acc = 1; m_stat = m_stat | 32'h2008;
      end else begin
        pga = (ste & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4);
        pte = rd(pga);
        newpte = pte;
        if (!pte[0]) begin
          f = 1; lat = 5; acc = 2; m_stat = m_stat | 32'h4008;
        end else if (wr && pte[2]) begin
          f = 1; lat = 5; acc = 2; m_stat = m_stat | 32'h2008;
        end else begin
          pa = (pte & 32'hFFFF_F000) | (va & 32'hFFF);
          ci = pte[6];
          newpte = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
          wb = (newpte != pte);
          lat = wb ? 6 : 5; acc = wb ? 3 : 2;
        end
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, {req, " R11 idle ready"}, {31'b0, req_ready}, 1);
    req_valid = 1; req_vaddr = va; req_write = wr; req_super = sup;
    mem_cnt = 0;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 0;
      chk(rsp_valid == (k == lat), {req, " R11 rsp timing"},
          {31'b0, rsp_valid}, {31'b0, (k == lat)});
      chk(req_ready == 1'b0, {req, " R11 busy"}, {31'b0, req_ready}, 0);
    end
    chk(rsp_fault == f, {req, " fault flag"}, {31'b0, rsp_fault}, {31'b0, f});
    chk(rsp_paddr == pa, {req, " paddr"}, rsp_paddr, pa);
    chk(rsp_cinh == ci, {req, " cinh"}, {31'b0, rsp_cinh}, {31'b0, ci});
    chk(mem_cnt == acc, {req, " memory accesses"}, mem_cnt, acc);
    rreg(2'd2, m_stat, {req, " status R8"});
    if (pga != 0) chk(rd(pga) == newpte, {req, " R6 page word"}, rd(pga), newpte);
    @(negedge clk);
    chk(rsp_valid == 1'b0, {req, " R11 pulse"}, {31'b0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // tables
    bmem[32'h20004 >> 2] = 32'h0003_000A;  // user seg 1 -> PT 0x30000
    bmem[32'h2000C >> 2] = 32'h0003_000E;  // user seg 3 read-only
    bmem[32'h20008 >> 2] = 32'h0000_0001;  // user seg 2: only bit0
    bmem[32'h10004 >> 2] = 32'h0004_000A;  // sup seg 1 -> PT 0x40000
    bmem[32'h3000C >> 2] = 32'h1234_5001;
    bmem[32'h30014 >> 2] = 32'h7777_7002;  // only bit1: invalid page
    bmem[32'h30018 >> 2] = 32'h6666_6005;  // read-only page
    bmem[32'h30004 >> 2] = 32'h4444_4019;  // ref+mod already set
    bmem[32'h4000C >> 2] = 32'h5555_5041;  // cache inhibit
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1 && rsp_valid == 0, "reset R11", {req_ready, rsp_valid}, 2);
    rreg(2'd0, 0, "reset R12 sroot");
    rreg(2'd1, 0, "reset R12 uroot");
    rreg(2'd2, 0, "reset R12 status");
    // R9 pass-through while disabled
    xlate(32'h0040_3123, 0, 0, "R9 user bypass");
    xlate(32'hDEAD_BEEF, 1, 1, "R9 sup bypass");
    wreg(2'd0, 32'hFFF0_0010);
    wreg(2'd1, 32'h0000_0020);
    rreg(2'd0, 32'h10, "R12 sroot width");
    wreg(2'd2, 32'hFFFF_FFFF & ~32'hE008);
    rreg(2'd2, 32'h3, "R12 status mask");
    // R1 R6 translate, reference write-back
    xlate(32'h0040_3123, 0, 0, "R1 R6 first read");
    xlate(32'h0040_3456, 0, 0, "R6 reread no wb");
    xlate(32'h0040_3FFF, 1, 0, "R6 write sets modify");
    // R2 R7 supervisor root, cache inhibit
    xlate(32'h0040_3123, 0, 1, "R2 R7 sup");
    // R3 invalid segment
    xlate(32'h0080_0000, 0, 0, "R3 R10 seg invalid");
    // R8 sticky across success
    xlate(32'h0040_3000, 0, 0, "R8 sticky");
    wreg(2'd2, 32'h3);
    rreg(2'd2, 32'h3, "R8 sw clear");
    // R4 invalid page
    xlate(32'h0040_5000, 0, 0, "R4 page invalid");
    wreg(2'd2, 32'h3);
    // R5 protection
    xlate(32'h0040_6010, 1, 0, "R5 ro page write");
    wreg(2'd2, 32'h3);
    xlate(32'h0040_6010, 0, 0, "R5 ro page read");
    xlate(32'h00C0_1000, 0, 0, "R5 ro seg read");
    xlate(32'h00C0_1004, 1, 0, "R5 ro seg write");
    // R9 per-mode enable: sup off, user on
    wreg(2'd2, 32'h1);
    xlate(32'h0040_3123, 0, 1, "R9 sup off");
    xlate(32'h0040_3123, 0, 0, "R9 user on");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule